// File: doc/BRIEF.md
# Host Command and Data Register Interface

This block is the host-facing front of a multi-channel serial controller. A host on a simple memory-mapped bus sees one 32-bit command register, one 32-bit data register and one read-only fault byte per channel. Through the command register it starts parameter reads and writes on a local parameter port, starts transfers on any set of channels, and clears sticky channel fault bytes. The command register also works as the busy flag: it keeps the written command until the operation has finished and then reads zero. The host polls it for zero before it issues the next command.

The serial channels and the parameter store sit outside the block and are reached by simple handshakes. Each channel takes a one-cycle start pulse and answers with a done pulse and an error byte. The parameter port takes a one-cycle request and answers with a done pulse and, on a read, a byte. When a transfer command finishes, the data register holds a one-bit-per-channel summary, so the host can find failed channels with a single read. Any command write with bit 31 set is dropped, so hosts that replay a fixed address list can write a harmless dummy value.

Top module: `host_cmd_regs`

## Requirements
- R1: A write to the command register (address 0) with bit 31 set has no effect: the command register stays zero, no channel start pulse and no parameter request follow.
- R2: While an operation is pending, the command register reads back the value written. It reads zero once the operation completes. Writes to the command or the data register (address 1) are ignored while the command register is nonzero.
- R3: A parameter write is the command 0xA000 ORed with the address in bits 10:0 (bit 15 write, bit 13 request). It gives one parReq pulse in the next cycle, with parWr high, parAddr equal to the address and parWrData equal to data register bits 7:0. The command register reads zero in the cycle after parDone is sampled.
- R4: A parameter read is the command 0x2000 ORed with the address (bit 13 set, bit 15 clear). It gives parReq with parWr low. When parDone is sampled, the data register takes parRdData zero-extended and the command register clears.
- R5: A transfer command 0x10NN gives, in the cycle after the write, a one-cycle pulse on chStart equal to the mask NN (bit i selects channel i).
- R6: After a transfer command, the command register clears only in the cycle after the last selected channel's chDone is sampled. chDone and chErr from unselected channels are ignored. A mask of zero completes after one cycle.
- R7: When a transfer completes, data register bit i is 1 exactly when channel i was selected and reported a nonzero chErr with its done. All other bits are 0.
- R8: Address 2+i reads channel i's fault byte in bits 7:0. The byte accumulates, by OR, every chErr byte that channel reports with a done while it is selected. Bit meanings, 7 down to 0: too many errors, remote fault, serial break, extra character, timeout, overrun, invalid cookie, CRC.
- R9: A stop command 0x40NN clears the fault bytes of the channels set in NN and leaves the others unchanged. It completes at once, so the command register keeps reading zero.
- R10: A command whose bits 15:12 are not 0x1, 0x2, 0x4 or 0xA is dropped, and the command register stays zero.
- R11: After reset, the command register, the data register and all fault bytes read zero, and chStart and parReq are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | AW | Register address: 0 command, 1 data, 2+i fault byte i |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, combinational |
| chStart | output | NUM_CH | One-cycle transfer start per channel |
| chDone | input | NUM_CH | Transfer finished per channel |
| chErr | input | NUM_CH*8 | Error byte of channel i in bits 8i+7:8i, valid with chDone |
| parReq | output | 1 | One-cycle parameter access request |
| parWr | output | 1 | Parameter access is a write |
| parAddr | output | PAW | Parameter address |
| parWrData | output | 8 | Parameter write byte |
| parDone | input | 1 | Parameter access finished |
| parRdData | input | 8 | Parameter read byte, valid with parDone |

## Verification
The hardest case to reach is a transfer in which channels finish on different cycles and unselected channels pulse done with nonzero error bytes at the same time. Only then can the bench tell that completion waits for the last selected channel and that stray reports are kept out of the summary and the fault bytes. The bench sweeps every 8-bit mask against a channel model whose per-channel delay and error byte are computed from the mask and the channel number. Unselected channels answer as well, with 0xFF. The bench measures the number of cycles before the command register reads zero. It interleaves stop commands with shifting masks, and it tries command and data writes while a transfer is still running.

// File: rtl/hcr_pkg.sv
package hcr_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_TRIG, ST_PARAM} state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCmd;
    logic clearCmd;
    logic loadData;
    logic startTrig;
    logic startPar;
    logic finishTrig;
    logic finishRead;
    logic clearFaults;
  } strobe_t;

  localparam logic [3:0] OP_TRIG  = 4'h1;
  localparam logic [3:0] OP_PREAD = 4'h2;
  localparam logic [3:0] OP_STOP  = 4'h4;
  localparam logic [3:0] OP_PWRITE = 4'hA;
endpackage

// File: rtl/hcr_ctrl.sv
module hcr_ctrl
  import hcr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWrEn,
  input  logic        cmdSel,
  input  logic        dataSel,
  input  logic        cmdMsb,
  input  logic [3:0]  cmdOp,
  input  logic        pendDone,
  input  logic        parDone,
  output strobe_t     strb,
  output logic        busy
);
  state_t state, nextState;
  logic   rdFlag;

  always_comb begin
    strb      = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (busWrEn && dataSel) strb.loadData = 1'b1;
        if (busWrEn && cmdSel && !cmdMsb) begin
          unique case (cmdOp)
            OP_TRIG: begin
              strb.loadCmd   = 1'b1;
              strb.startTrig = 1'b1;
              nextState      = ST_TRIG;
            end
            OP_PREAD, OP_PWRITE: begin
              strb.loadCmd  = 1'b1;
              strb.startPar = 1'b1;
              nextState     = ST_PARAM;
            end
            OP_STOP: strb.clearFaults = 1'b1;
            default: ;
          endcase
        end
      end
      ST_TRIG: begin
        if (pendDone) begin
          strb.finishTrig = 1'b1;
          strb.clearCmd   = 1'b1;
          nextState       = ST_IDLE;
        end
      end
      ST_PARAM: begin
        if (parDone) begin
          strb.clearCmd   = 1'b1;
          strb.finishRead = rdFlag;
          nextState       = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      rdFlag <= 1'b0;
    end else begin
      state <= nextState;
      if (strb.startPar) rdFlag <= (cmdOp == OP_PREAD);
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/hcr_dp.sv
module hcr_dp
  import hcr_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int PAW    = 11,
  parameter int AW     = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic [AW-1:0]       busAddr,
  input  logic [31:0]         busWrData,
  output logic [31:0]         busRdData,
  output logic [NUM_CH-1:0]   chStart,
  input  logic [NUM_CH-1:0]   chDone,
  input  logic [NUM_CH*8-1:0] chErr,
  output logic                parReq,
  output logic                parWr,
  output logic [PAW-1:0]      parAddr,
  output logic [7:0]          parWrData,
  input  logic [7:0]          parRdData,
  output logic                pendDone,
  output logic [31:0]         cmdQ,
  output logic [NUM_CH*8-1:0] faultFlat
);
  localparam int WR_BIT = 15;

  logic [31:0]       dataQ;
  logic [NUM_CH-1:0] pendQ, sumQ, failNow, pendNext;
  logic [7:0]        fault [NUM_CH];

  assign pendNext  = pendQ & ~chDone;
  assign pendDone  = (pendNext == '0);
  assign parWrData = dataQ[7:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ    <= '0;
      dataQ   <= '0;
      pendQ   <= '0;
      sumQ    <= '0;
      chStart <= '0;
      parReq  <= 1'b0;
      parWr   <= 1'b0;
      parAddr <= '0;
    end else begin
      if (strb.loadCmd)       cmdQ <= busWrData;
      else if (strb.clearCmd) cmdQ <= '0;

      if (strb.loadData)        dataQ <= busWrData;
      else if (strb.finishTrig) dataQ <= 32'(sumQ | failNow);
      else if (strb.finishRead) dataQ <= {24'd0, parRdData};

      if (strb.startTrig) begin
        pendQ <= busWrData[NUM_CH-1:0];
        sumQ  <= '0;
      end else begin
        pendQ <= pendNext;
        sumQ  <= sumQ | failNow;
      end

      chStart <= strb.startTrig ? busWrData[NUM_CH-1:0] : '0;
      parReq  <= strb.startPar;
      if (strb.startPar) begin
        parWr   <= busWrData[WR_BIT];
        parAddr <= busWrData[PAW-1:0];
      end
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [7:0] errByte;
    assign errByte    = chErr[g*8 +: 8];
    assign failNow[g] = chDone[g] && pendQ[g] && (errByte != 8'd0);
    assign faultFlat[g*8 +: 8] = fault[g];

    always_ff @(posedge clk) begin
      if (!rstN)                                  fault[g] <= '0;
      else if (strb.clearFaults && busWrData[g])  fault[g] <= '0;
      else if (chDone[g] && pendQ[g])             fault[g] <= fault[g] | errByte;
    end
  end

  always_comb begin
    busRdData = '0;
    if (busAddr == AW'(0))      busRdData = cmdQ;
    else if (busAddr == AW'(1)) busRdData = dataQ;
    for (int i = 0; i < NUM_CH; i++)
      if (busAddr == AW'(i + 2)) busRdData = {24'd0, fault[i]};
  end
endmodule

// File: rtl/host_cmd_regs.sv
module host_cmd_regs
  import hcr_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int PAW    = 11,
  parameter int AW     = $clog2(NUM_CH + 2)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrEn,
  input  logic [AW-1:0]       busAddr,
  input  logic [31:0]         busWrData,
  output logic [31:0]         busRdData,
  output logic [NUM_CH-1:0]   chStart,
  input  logic [NUM_CH-1:0]   chDone,
  input  logic [NUM_CH*8-1:0] chErr,
  output logic                parReq,
  output logic                parWr,
  output logic [PAW-1:0]      parAddr,
  output logic [7:0]          parWrData,
  input  logic                parDone,
  input  logic [7:0]          parRdData
);
  strobe_t             strb;
  logic                busy, pendDone, cmdSel, dataSel;
  logic [31:0]         cmdQ;
  logic [NUM_CH*8-1:0] faultFlat;

  assign cmdSel  = (busAddr == AW'(0));
  assign dataSel = (busAddr == AW'(1));

  hcr_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busWrEn  (busWrEn),
    .cmdSel   (cmdSel),
    .dataSel  (dataSel),
    .cmdMsb   (busWrData[31]),
    .cmdOp    (busWrData[15:12]),
    .pendDone (pendDone),
    .parDone  (parDone),
    .strb     (strb),
    .busy     (busy)
  );

  hcr_dp #(.NUM_CH(NUM_CH), .PAW(PAW), .AW(AW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .chStart   (chStart),
    .chDone    (chDone),
    .chErr     (chErr),
    .parReq    (parReq),
    .parWr     (parWr),
    .parAddr   (parAddr),
    .parWrData (parWrData),
    .parRdData (parRdData),
    .pendDone  (pendDone),
    .cmdQ      (cmdQ),
    .faultFlat (faultFlat)
  );
endmodule

// File: rtl/hcr_checker.sv
module hcr_checker #(
  parameter int NUM_CH = 8,
  parameter int AW     = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                busWrEn,
  input logic [AW-1:0]       busAddr,
  input logic [31:0]         busWrData,
  input logic [NUM_CH-1:0]   chStart,
  input logic                parReq,
  input logic [31:0]         cmdQ,
  input logic                busy,
  input logic [NUM_CH*8-1:0] faultFlat
);
  logic idleCmdWr, stopNow, trigNow, msbNow;
  assign idleCmdWr = !busy && busWrEn && (busAddr == AW'(0));
  assign msbNow    = idleCmdWr && busWrData[31];
  assign trigNow   = idleCmdWr && !busWrData[31] && (busWrData[15:12] == 4'h1);
  assign stopNow   = idleCmdWr && !busWrData[31] && (busWrData[15:12] == 4'h4);

  AST_MSB_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    msbNow |=> (cmdQ == 32'd0) && (chStart == '0) && !parReq);  // R1

  AST_BUSY_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (cmdQ != 32'd0));  // R2

  AST_PARREQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    parReq |=> !parReq);  // R3

  AST_START_MASK: assert property (@(posedge clk) disable iff (!rstN)
    trigNow |=> (chStart == $past(busWrData[NUM_CH-1:0])));  // R5

  AST_START_ONLY_ON_TRIG: assert property (@(posedge clk) disable iff (!rstN)
    !trigNow |=> (chStart == '0));  // R5

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !stopNow |=> ((faultFlat & $past(faultFlat)) == $past(faultFlat)));  // R8
endmodule

bind host_cmd_regs hcr_checker #(.NUM_CH(NUM_CH), .AW(AW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busWrEn   (busWrEn),
  .busAddr   (busAddr),
  .busWrData (busWrData),
  .chStart   (chStart),
  .parReq    (parReq),
  .cmdQ      (cmdQ),
  .busy      (busy),
  .faultFlat (faultFlat)
);

// File: tb/host_cmd_regs_tb.sv
module host_cmd_regs_tb;
  localparam int NUM_CH = 8;
  localparam int PAW    = 11;
  localparam int AW     = 4;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                busWrEn = 1'b0;
  logic [AW-1:0]       busAddr = '0;
  logic [31:0]         busWrData = '0;
  logic [31:0]         busRdData;
  logic [NUM_CH-1:0]   chStart;
  logic [NUM_CH-1:0]   chDone = '0;
  logic [NUM_CH*8-1:0] chErr = '0;
  logic                parReq, parWr;
  logic [PAW-1:0]      parAddr;
  logic [7:0]          parWrData;
  logic                parDone = 1'b0;
  logic [7:0]          parRdData = '0;

  int testCnt = 0, failCnt = 0, cycles = 0;
  int curMask = 0;
  int cnt [NUM_CH];
  logic [7:0] expFault [NUM_CH];
  int pCnt = 0;
  logic recWr;
  logic [PAW-1:0] recAddr;
  logic [7:0] recData;

  always #10 clk = ~clk;

  host_cmd_regs #(.NUM_CH(NUM_CH), .PAW(PAW)) u_dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .chStart(chStart),
    .chDone(chDone), .chErr(chErr), .parReq(parReq), .parWr(parWr),
    .parAddr(parAddr), .parWrData(parWrData), .parDone(parDone),
    .parRdData(parRdData)
  );

  function automatic int chDelay(int m, int i);
    return ((m + i) % 4) + 1;
  endfunction

  function automatic logic [7:0] chErrVal(int m, int i);
    if ((((m >> i) ^ i) & 1) != 0) return 8'(1 << ((m + i) % 8));
    return 8'd0;
  endfunction

  // channel and parameter models
  always @(negedge clk) begin
    chDone  = '0;
    chErr   = '0;
    parDone = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (cnt[i] > 0) begin
        cnt[i]--;
        if (cnt[i] == 0) begin
          chDone[i] = 1'b1;
          chErr[i*8 +: 8] = ((curMask >> i) & 1) != 0 ? chErrVal(curMask, i) : 8'hFF;
        end
      end
    end
    if (chStart != '0)
      for (int i = 0; i < NUM_CH; i++) cnt[i] = chDelay(curMask, i);
    if (pCnt > 0) begin
      pCnt--;
      if (pCnt == 0) begin
        parDone   = 1'b1;
        parRdData = recAddr[7:0] ^ 8'h5A;
      end
    end
    if (parReq) begin
      recWr = parWr; recAddr = parAddr; recData = parWrData; pCnt = 2;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failCnt++;
      testCnt++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // drive at negedge, sampled at next posedge, return at the following negedge
  task automatic wrReg(int a, logic [31:0] v);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = AW'(a); busWrData = v;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rdReg(int a, output logic [31:0] v);
    busAddr = AW'(a);
    #1 v = busRdData;
  endtask

  task automatic pollIdle(output int k);
    logic [31:0] v;
    k = 0;
    rdReg(0, v);
    while (v != 0 && k < 40) begin
      @(negedge clk);
      k++;
      rdReg(0, v);
    end
  endtask

  task automatic checkFaults(string req);
    logic [31:0] v;
    for (int i = 0; i < NUM_CH; i++) begin
      rdReg(i + 2, v);
      check(req, v, {24'd0, expFault[i]});
    end
  endtask

  task automatic runTrig(int m, bit fullCheck);
    logic [31:0] v;
    int k, dMax;
    logic [NUM_CH-1:0] sum;
    curMask = m;
    dMax = 0; sum = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (((m >> i) & 1) != 0) begin
        if (chDelay(m, i) > dMax) dMax = chDelay(m, i);
        if (chErrVal(m, i) != 0) sum[i] = 1'b1;
        expFault[i] |= chErrVal(m, i);
      end
    wrReg(0, 32'h1000 | 32'(m));
    check("R5 start mask", 32'(chStart), 32'(m));
    rdReg(0, v);
    check("R2 busy readback", v, 32'h1000 | 32'(m));
    pollIdle(k);
    check("R6 completion cycle", 32'(k), 32'(dMax + 1));
    rdReg(1, v);
    check("R7 summary", v, 32'(sum));
    if (fullCheck) checkFaults("R8 fault bytes");
  endtask

  initial begin
    logic [31:0] v;
    int k;
    for (int i = 0; i < NUM_CH; i++) begin cnt[i] = 0; expFault[i] = 8'd0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11 reset state
    rdReg(0, v); check("R11 cmd", v, 0);
    rdReg(1, v); check("R11 data", v, 0);
    check("R11 chStart", 32'(chStart), 0);
    check("R11 parReq", 32'(parReq), 0);
    checkFaults("R11 faults");

    // R1 bit 31 set: dropped
    wrReg(0, 32'h800010FF);
    check("R1 no start", 32'(chStart), 0);
    rdReg(0, v); check("R1 cmd", v, 0);
    check("R1 no parReq", 32'(parReq), 0);
    wrReg(0, 32'h8000A001);
    check("R1 no parReq write form", 32'(parReq), 0);

    // R10 unknown opcode
    wrReg(0, 32'h00003055);
    rdReg(0, v); check("R10 cmd stays zero", v, 0);
    check("R10 no start", 32'(chStart), 0);

    // R6 zero mask
    runTrig(0, 1'b1);

    // sweep all masks with periodic stops
    for (int m = 1; m < 256; m++) begin
      runTrig(m, (m % 16) == 0);
      if ((m % 32) == 7) begin
        int sm = (m ^ 8'hA5) & 8'hFF;
        for (int i = 0; i < NUM_CH; i++) if (((sm >> i) & 1) != 0) expFault[i] = 8'd0;
        wrReg(0, 32'h4000 | 32'(sm));
        rdReg(0, v); check("R9 stop not busy", v, 0);
        checkFaults("R9 stop clears masked");
      end
    end

    // R2 writes during busy are ignored
    begin
      logic [NUM_CH-1:0] sum = '0;
      curMask = 8'hFF;
      for (int i = 0; i < NUM_CH; i++) begin
        expFault[i] |= chErrVal(8'hFF, i);
        if (chErrVal(8'hFF, i) != 0) sum[i] = 1'b1;
      end
      wrReg(0, 32'h000010FF);
      wrReg(0, 32'h00001003);
      rdReg(0, v); check("R2 cmd write while busy", v, 32'h000010FF);
      wrReg(1, 32'h12345678);
      pollIdle(k);
      rdReg(1, v); check("R2 data write while busy", v, 32'(sum));
      checkFaults("R8 after busy test");
    end

    // R9 stop all
    wrReg(0, 32'h000040FF);
    for (int i = 0; i < NUM_CH; i++) expFault[i] = 8'd0;
    checkFaults("R9 stop all");

    // R3 / R4 parameter sweep
    for (int a = 0; a < 64; a++) begin
      logic [PAW-1:0] pa = PAW'((a * 37 + a * a * 5) % 2048);
      logic [7:0] dv = 8'(a * 3 + 1);
      wrReg(1, {24'hABCDE0, dv} ^ 32'h00000000);
      wrReg(0, 32'hA000 | 32'(pa));
      pollIdle(k);
      check("R3 param write latency", 32'(k), 3);
      check("R3 parWr", 32'(recWr), 1);
      check("R3 parAddr", 32'(recAddr), 32'(pa));
      check("R3 parWrData", 32'(recData), 32'(dv));
      wrReg(0, 32'h2000 | 32'(pa));
      pollIdle(k);
      check("R4 param read latency", 32'(k), 3);
      check("R4 parWr low", 32'(recWr), 0);
      rdReg(1, v); check("R4 read byte", v, 32'(pa[7:0] ^ 8'h5A));
    end

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule